// File: doc/BRIEF.md
# Clock-Crossing Register Write Bridge

This block lets a bus running on the system clock update a small bank of registers that are clocked by a second, unrelated clock. A bus write is taken into holding registers on the system side. A request toggle then crosses into the far domain through a chain of synchronizer flops. The far side applies the write and returns an acknowledge toggle the same way. A software-visible completion flag drops on the cycle after a write is taken. It rises again only once the acknowledge has come back, which means the far register already holds the new value.

Reads never wait. The system side keeps a shadow copy of every far register. The shadow entry is refreshed when the acknowledge returns, and a read returns the shadow contents one cycle later. A write issued while the completion flag is low is discarded and sets a sticky error flag. The `SAME_CLOCK` parameter builds a variant for a target register bank that runs on the system clock. In that variant no synchronizer is built, the completion flag stays high, and back-to-back writes are all taken.

Top module: `cdcwr_bridge`

## Requirements
- R1: After reset the completion flag is 1, the error flag is 0, the read data is 0 and every far register is 0.
- R2: A write taken while the completion flag is 1 drives the completion flag to 0 from the next system clock cycle.
- R3: When the completion flag returns to 1, the far register at the written address already holds the written data.
- R4: Every write that is taken updates the far registers exactly once, in the order taken, with a one-cycle far-domain strobe carrying the address.
- R5: A write issued while the completion flag is 0 is discarded. It changes no far register and no shadow entry, and it sets the error flag, which then stays at 1 until reset.
- R6: A read returns data one system cycle after the read enable, whatever the completion flag shows, and reads may be issued on consecutive cycles.
- R7: A read returns the last completed value. While a write is still in flight, a read of its address returns the previous value.
- R8: The holding address and data stay unchanged for as long as a write is in flight.
- R9: With `SAME_CLOCK` set, the completion flag stays 1, writes on consecutive cycles are all taken, each lands in the far register two cycles after it is issued, and a read issued on the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System (bus) clock |
| sysRstN | input | 1 | Active-low asynchronous reset, system side |
| busWrEn | input | 1 | Write request, one cycle per write |
| busRdEn | input | 1 | Read request |
| busAddr | input | ADDR_W | Register address for a read or write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, valid one cycle after busRdEn |
| wrDone | output | 1 | Completion flag: 1 when a new access may start |
| wrDropErr | output | 1 | Sticky flag: a write was discarded |
| farClk | input | 1 | Clock of the target register bank |
| farRstN | input | 1 | Active-low asynchronous reset, far side |
| farRegs | output | (2**ADDR_W)*DATA_W | Far register bank, register i at bits i*DATA_W upward |
| farWrStrobe | output | 1 | One far-cycle pulse when a write lands |
| farWrAddr | output | ADDR_W | Address of the write that just landed |

## Verification
The bench builds the main instance with ADDR_W=2, DATA_W=32 and SYNC_STAGES=2, and runs the far clock at 37 ns against an 8 ns system clock. Because the two periods share no simple ratio, the acknowledge arrives at varying phases across the write sequence, and each write stays in flight long enough for a read and a discarded write to be issued in the middle of it. A second instance is built with SAME_CLOCK=1, with both clocks tied to the system clock. It shows the variant with no gap and writes taken on consecutive cycles.

// File: rtl/cdcwr_pkg.sv
package cdcwr_pkg;
  // strobes from the control path into the datapath
  typedef struct packed {
    logic capture;  // take bus address/data into the holding registers
    logic commit;   // far side has acknowledged: refresh the shadow entry
  } wrStrobe_t;
endpackage

// File: rtl/cdcwr_ctrl.sv
module cdcwr_ctrl
  import cdcwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit SAME_CLOCK  = 1'b0
) (
  input  logic       sysClk,
  input  logic       sysRstN,
  input  logic       busWrEn,
  input  logic       ackTgl,
  output logic       reqTgl,
  output logic       wrDone,
  output logic       wrDropErr,
  output wrStrobe_t  strobe
);
  logic accept;
  logic dropWr;

  assign accept = busWrEn && wrDone;
  assign dropWr = busWrEn && !wrDone;
  assign strobe.capture = accept;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      reqTgl    <= 1'b0;
      wrDropErr <= 1'b0;
    end else begin
      if (accept) reqTgl <= ~reqTgl;
      if (dropWr) wrDropErr <= 1'b1;
    end
  end

  generate
    if (SAME_CLOCK) begin : g_sameClk
      assign wrDone        = 1'b1;
      assign strobe.commit = accept;
    end else begin : g_crossClk
      logic [SYNC_STAGES-1:0] ackSync;
      logic                   ackSeen;
      logic                   busyQ;
      logic                   ackBack;

      always_ff @(posedge sysClk or negedge sysRstN) begin
        if (!sysRstN) ackSync <= '0;
        else          ackSync <= {ackSync[SYNC_STAGES-2:0], ackTgl};
      end
      assign ackSeen = ackSync[SYNC_STAGES-1];
      assign ackBack = busyQ && (ackSeen == reqTgl);

      always_ff @(posedge sysClk or negedge sysRstN) begin
        if (!sysRstN)     busyQ <= 1'b0;
        else if (accept)  busyQ <= 1'b1;
        else if (ackBack) busyQ <= 1'b0;
      end

      assign wrDone        = !busyQ;
      assign strobe.commit = ackBack;

      p_done_low_after_accept_r2: assert property (
        @(posedge sysClk) disable iff (!sysRstN) busWrEn && wrDone |=> !wrDone);
    end
  endgenerate

  p_drop_sets_err_r5: assert property (
    @(posedge sysClk) disable iff (!sysRstN) busWrEn && !wrDone |=> wrDropErr);
  p_err_sticky_r5: assert property (
    @(posedge sysClk) disable iff (!sysRstN) wrDropErr |=> wrDropErr);
endmodule

// File: rtl/cdcwr_dpath.sv
module cdcwr_dpath
  import cdcwr_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter bit SAME_CLOCK = 1'b0
) (
  input  logic              sysClk,
  input  logic              sysRstN,
  input  wrStrobe_t         strobe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [ADDR_W-1:0] holdAddr,
  output logic [DATA_W-1:0] holdData,
  output logic [DATA_W-1:0] busRdData
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] shadow [NUM_REGS];
  logic [ADDR_W-1:0] commitAddr;
  logic [DATA_W-1:0] commitData;

  generate
    if (SAME_CLOCK) begin : g_direct
      assign commitAddr = busAddr;
      assign commitData = busWrData;
    end else begin : g_held
      assign commitAddr = holdAddr;
      assign commitData = holdData;
    end
  endgenerate

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      holdAddr <= '0;
      holdData <= '0;
    end else if (strobe.capture) begin
      holdAddr <= busAddr;
      holdData <= busWrData;
    end
  end

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      for (int i = 0; i < NUM_REGS; i++) shadow[i] <= '0;
      busRdData <= '0;
    end else begin
      if (strobe.commit) shadow[commitAddr] <= commitData;
      if (busRdEn)       busRdData <= shadow[busAddr];
    end
  end

  p_hold_stable_r8: assert property (
    @(posedge sysClk) disable iff (!sysRstN)
    busy |=> $stable(holdAddr) && $stable(holdData));
endmodule

// File: rtl/cdcwr_far.sv
module cdcwr_far #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SAME_CLOCK  = 1'b0
) (
  input  logic                              farClk,
  input  logic                              farRstN,
  input  logic                              reqTgl,
  input  logic [ADDR_W-1:0]                 holdAddr,
  input  logic [DATA_W-1:0]                 holdData,
  output logic                              ackTgl,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     farRegs,
  output logic                              farWrStrobe,
  output logic [ADDR_W-1:0]                 farWrAddr
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regBank [NUM_REGS];
  logic              reqSeen;
  logic              lastReq;
  logic              apply;

  generate
    if (SAME_CLOCK) begin : g_noSync
      assign reqSeen = reqTgl;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] reqSync;
      always_ff @(posedge farClk or negedge farRstN) begin
        if (!farRstN) reqSync <= '0;
        else          reqSync <= {reqSync[SYNC_STAGES-2:0], reqTgl};
      end
      assign reqSeen = reqSync[SYNC_STAGES-1];
    end
  endgenerate

  assign apply  = reqSeen != lastReq;
  assign ackTgl = lastReq;

  always_ff @(posedge farClk or negedge farRstN) begin
    if (!farRstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
      lastReq     <= 1'b0;
      farWrStrobe <= 1'b0;
      farWrAddr   <= '0;
    end else begin
      farWrStrobe <= apply;
      if (apply) begin
        regBank[holdAddr] <= holdData;
        lastReq           <= reqSeen;
        farWrAddr         <= holdAddr;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign farRegs[g*DATA_W +: DATA_W] = regBank[g];
  end

  // a crossed request needs a full round trip, so strobes never touch
  p_single_strobe_r4: assert property (
    @(posedge farClk) disable iff (!farRstN)
    !SAME_CLOCK && farWrStrobe |=> !farWrStrobe);
endmodule

// File: rtl/cdcwr_bridge.sv
module cdcwr_bridge
  import cdcwr_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SAME_CLOCK  = 1'b0
) (
  input  logic                          sysClk,
  input  logic                          sysRstN,
  input  logic                          busWrEn,
  input  logic                          busRdEn,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  output logic                          wrDone,
  output logic                          wrDropErr,
  input  logic                          farClk,
  input  logic                          farRstN,
  output logic [(1<<ADDR_W)*DATA_W-1:0] farRegs,
  output logic                          farWrStrobe,
  output logic [ADDR_W-1:0]             farWrAddr
);
  wrStrobe_t         strobe;
  logic              reqTgl;
  logic              ackTgl;
  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;

  cdcwr_ctrl #(.SYNC_STAGES(SYNC_STAGES), .SAME_CLOCK(SAME_CLOCK)) ctrl_i (
    .sysClk(sysClk), .sysRstN(sysRstN), .busWrEn(busWrEn), .ackTgl(ackTgl),
    .reqTgl(reqTgl), .wrDone(wrDone), .wrDropErr(wrDropErr), .strobe(strobe));

  cdcwr_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAME_CLOCK(SAME_CLOCK)) dpath_i (
    .sysClk(sysClk), .sysRstN(sysRstN), .strobe(strobe), .busy(!wrDone),
    .busAddr(busAddr), .busWrData(busWrData), .busRdEn(busRdEn),
    .holdAddr(holdAddr), .holdData(holdData), .busRdData(busRdData));

  cdcwr_far #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
              .SAME_CLOCK(SAME_CLOCK)) far_i (
    .farClk(farClk), .farRstN(farRstN), .reqTgl(reqTgl), .holdAddr(holdAddr),
    .holdData(holdData), .ackTgl(ackTgl), .farRegs(farRegs),
    .farWrStrobe(farWrStrobe), .farWrAddr(farWrAddr));
endmodule

// File: tb/cdcwr_bridge_tb_top.sv
module cdcwr_bridge_tb_top;
  localparam int AW = 2;
  localparam int DW = 32;
  localparam int NR = 1 << AW;

  logic sysClk = 1'b0, farClk = 1'b0;
  logic sysRstN = 1'b0, farRstN = 1'b0;
  always #4    sysClk = ~sysClk;   // 125 MHz
  always #18.5 farClk = ~farClk;   // 37 ns

  logic          busWrEn = 0, busRdEn = 0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic          wrDone, wrDropErr;
  logic [NR*DW-1:0] farRegs;
  logic          farWrStrobe;
  logic [AW-1:0] farWrAddr;

  logic          sWrEn = 0, sRdEn = 0;
  logic [AW-1:0] sAddr = '0;
  logic [DW-1:0] sWrData = '0;
  logic [DW-1:0] sRdData;
  logic          sDone, sErr;
  logic [NR*DW-1:0] sRegs;
  logic          sStrobe;
  logic [AW-1:0] sStrobeAddr;

  cdcwr_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .SAME_CLOCK(1'b0)) dut_i (
    .sysClk(sysClk), .sysRstN(sysRstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .wrDone(wrDone), .wrDropErr(wrDropErr), .farClk(farClk), .farRstN(farRstN),
    .farRegs(farRegs), .farWrStrobe(farWrStrobe), .farWrAddr(farWrAddr));

  cdcwr_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .SAME_CLOCK(1'b1)) dut_same_i (
    .sysClk(sysClk), .sysRstN(sysRstN), .busWrEn(sWrEn), .busRdEn(sRdEn),
    .busAddr(sAddr), .busWrData(sWrData), .busRdData(sRdData),
    .wrDone(sDone), .wrDropErr(sErr), .farClk(sysClk), .farRstN(sysRstN),
    .farRegs(sRegs), .farWrStrobe(sStrobe), .farWrAddr(sStrobeAddr));

  int checks = 0, failures = 0, accepted = 0, landed = 0;
  bit finished = 0;
  logic [AW+DW-1:0] expQ[$];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] farSlice(input logic [NR*DW-1:0] bank, input int a);
    return bank[a*DW +: DW];
  endfunction

  // scoreboard monitor: each landing must match the oldest taken write (R4)
  always @(negedge farClk) begin
    if (farRstN && farWrStrobe) begin
      landed++;
      if (expQ.size() == 0) begin
        check("R4 unexpected landing", {30'd0, farWrAddr}, 32'hFFFF_FFFF);
      end else begin
        logic [AW+DW-1:0] item;
        item = expQ.pop_front();
        check("R4 landing addr", {30'd0, farWrAddr}, {30'd0, item[AW+DW-1:DW]});
        check("R4 landing data", farSlice(farRegs, int'(farWrAddr)), item[DW-1:0]);
      end
    end
  end

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, output bit acc);
    @(negedge sysClk);
    acc = wrDone;
    busWrEn = 1; busAddr = a; busWrData = d;
    if (acc) begin expQ.push_back({a, d}); accepted++; end
    @(negedge sysClk);
    busWrEn = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!wrDone && n < 400) begin @(negedge sysClk); n++; end
    check("R3 completion returns", {31'd0, wrDone}, 32'd1);
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge sysClk);
    busRdEn = 1; busAddr = a;
    @(negedge sysClk);
    busRdEn = 0;
    check(req, busRdData, exp);
  endtask

  initial begin
    repeat (150000) @(posedge sysClk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [DW-1:0] v;
    repeat (3) @(negedge farClk);
    sysRstN = 1; farRstN = 1;
    @(negedge sysClk);
    // R1
    check("R1 wrDone", {31'd0, wrDone}, 32'd1);
    check("R1 err", {31'd0, wrDropErr}, 32'd0);
    check("R1 rdata", busRdData, 32'd0);
    for (int i = 0; i < NR; i++) check("R1 far reg", farSlice(farRegs, i), 32'd0);

    // R2, R3, R7
    busWrite(2'd1, 32'hA5A5_0001, acc);
    check("R2 wrDone low", {31'd0, wrDone}, 32'd0);
    waitDone();
    check("R3 far holds data", farSlice(farRegs, 1), 32'hA5A5_0001);
    busRead(2'd1, 32'hA5A5_0001, "R7 read after completion");

    // R6/R7: read during flight returns old value
    busWrite(2'd1, 32'h1111_2222, acc);
    busRead(2'd1, 32'hA5A5_0001, "R6 R7 read while busy");
    check("R6 still busy", {31'd0, wrDone}, 32'd0);
    waitDone();
    busRead(2'd1, 32'h1111_2222, "R7 read new value");

    // R5: dropped write
    busWrite(2'd2, 32'hDEAD_BEEF, acc);
    busWrite(2'd3, 32'hBAD0_0003, acc);
    check("R5 drop not taken", {31'd0, acc}, 32'd0);
    check("R5 err set", {31'd0, wrDropErr}, 32'd1);
    waitDone();
    repeat (12) @(negedge farClk);
    @(negedge sysClk);
    check("R5 far reg untouched", farSlice(farRegs, 3), 32'd0);
    check("R3 far reg2", farSlice(farRegs, 2), 32'hDEAD_BEEF);
    busRead(2'd3, 32'd0, "R5 shadow untouched");

    // R6 back-to-back reads
    @(negedge sysClk);
    busRdEn = 1; busAddr = 2'd1;
    @(negedge sysClk);
    busAddr = 2'd2;
    check("R6 b2b read first", busRdData, 32'h1111_2222);
    @(negedge sysClk);
    busRdEn = 0;
    check("R6 b2b read second", busRdData, 32'hDEAD_BEEF);

    // several patterns
    for (int i = 0; i < 8; i++) begin
      v = (32'h0101_0101 * (i + 1)) ^ 32'hF0F0_0000;
      busWrite(2'(i % NR), v, acc);
      check("R2 taken", {31'd0, acc}, 32'd1);
      waitDone();
      check("R3 far pattern", farSlice(farRegs, i % NR), v);
      busRead(2'(i % NR), v, "R7 read pattern");
    end
    check("R5 err sticky", {31'd0, wrDropErr}, 32'd1);

    repeat (10) @(negedge farClk);
    check("R4 queue drained", expQ.size(), 32'd0);
    check("R4 landed once each", landed, accepted);

    // R9: same-clock variant
    @(negedge sysClk);
    sWrEn = 1; sAddr = 2'd0; sWrData = 32'h1234_5678;
    @(negedge sysClk);
    sWrEn = 0;
    check("R9 done stays high", {31'd0, sDone}, 32'd1);
    sRdEn = 1; sAddr = 2'd0;
    @(negedge sysClk);
    sRdEn = 0;
    check("R9 far landed", farSlice(sRegs, 0), 32'h1234_5678);
    check("R9 read next cycle", sRdData, 32'h1234_5678);
    @(negedge sysClk);
    sWrEn = 1; sAddr = 2'd2; sWrData = 32'hCAFE_0002;
    @(negedge sysClk);
    sAddr = 2'd3; sWrData = 32'hCAFE_0003;
    check("R9 done during b2b", {31'd0, sDone}, 32'd1);
    @(negedge sysClk);
    sWrEn = 0;
    @(negedge sysClk);
    check("R9 b2b first", farSlice(sRegs, 2), 32'hCAFE_0002);
    check("R9 b2b second", farSlice(sRegs, 3), 32'hCAFE_0003);
    check("R9 no err", {31'd0, sErr}, 32'd0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule